// File: doc/BRIEF.md
# Reed-Solomon ECC Register Front-End

This block sits between software and a Reed-Solomon codec core for NAND pages. Software reaches it through a simple word-wide bus slave: an address, a write enable, four byte strobes, write data, and combinational read data. The block holds a control register, a status register with finish flags, error flags and a corrected-error count, an interrupt mask, a nine-byte parity window that can be reached one byte at a time, and a small bank of error-record registers that the core fills during a decode.

A run begins when software writes the self-clearing reset bit. If enable and the encode bit are set, the core is started once the reset has taken effect. In decode mode the start is held back until software has loaded the parity bytes and raised the parity-ready bit. At the end of an encode, the parity from the core is captured into the window. If that parity equals the parity of an all-0xFF page, it is replaced by nine 0xFF bytes, so that erased pages keep erased spare bytes. The codec arithmetic itself lives in the core, outside this block.

Top module: `rsecc_regfront`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `irq` is 0 and `core_start` is 0.
- R2: The control word at byte address 0x00 holds enable in bit 0, reset in bit 1, RS mode in bit 2, encode in bit 3 (1 = compute parity, 0 = decode) and parity-ready in bit 4. It is written through byte lane 0. Bits 0, 2, 3 and 4 read back as written. `core_rs_mode` follows bit 2 and `core_encode` follows bit 3.
- R3: The reset bit reads 1 during the cycle after the write that set it and 0 after that. One cycle after that write, parity-ready is cleared, even if the same write set it.
- R4: A write that sets the reset bit arms one run. With enable and encode set, `core_start` is high for exactly one cycle, the second cycle after the write. Without a reset write, `core_start` stays low.
- R5: When encode is 0, `core_start` stays low until parity-ready is 1. It rises in the cycle after the write that sets parity-ready.
- R6: Parity byte i (0 to 8) sits at byte address 0x08+i. It lies in word 0x08+4*(i/4), lane i%4, and is written when that lane's strobe is set. `core_par_out` carries byte i in bits 8i+7:8i.
- R7: A `core_done` at the end of an encode loads `core_par_in` into the window, with byte i taken from bits 8i+7:8i. If the bytes 0..8 are CD 9D 90 58 F4 8B FF B7 6F, all nine window bytes read 0xFF instead.
- R8: The status word is at 0x14. Bit 0 means error, bit 1 uncorrectable, bit 2 encode done, bit 3 decode done, bit 4 pad done, and bits 31:29 hold the corrected-error count. A `core_done` while running sets bit 2 (encode), or bit 3 together with the core's error, uncorrectable and count values (decode). `core_pad_done` sets bit 4. Each result is readable in the cycle after the pulse.
- R9: Writing the value zero to the status word clears all its flags and the count. A write of any other value changes nothing.
- R10: Error record n is at 0x1C+4n. It is written from `core_rec_data` when `core_rec_we` is high with `core_rec_idx` equal to n. All records clear one cycle after a reset-bit write.
- R11: A control write that clears enable leaves the status word and the error records unchanged.
- R12: The interrupt mask is at 0x18, bits 4:0, written through lane 0. `irq` is high whenever some status bit 4:0 is set together with the mask bit in the same position.
- R13: A write to 0x04 presents the written word on `core_data` with `core_data_vld` high for the one following cycle. A read of 0x04 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; low two bits ignored |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq | output | 1 | Masked status interrupt |
| core_start | output | 1 | One-cycle start to the codec core |
| core_encode | output | 1 | 1 = encode, 0 = decode |
| core_rs_mode | output | 1 | RS mode select to the core |
| core_par_out | output | 72 | Parity bytes for decode |
| core_data_vld | output | 1 | Data word valid |
| core_data | output | 32 | Data word from software |
| core_done | input | 1 | Run finished pulse |
| core_pad_done | input | 1 | Padding finished pulse |
| core_err | input | 1 | Decode found errors |
| core_uncor | input | 1 | Decode errors are uncorrectable |
| core_err_cnt | input | 3 | Corrected-error count |
| core_par_in | input | 72 | Parity computed by an encode |
| core_rec_we | input | 1 | Error-record write |
| core_rec_idx | input | REC_IW | Error-record index |
| core_rec_data | input | 32 | Error-record value |

## Verification
Read data is combinational, so a register written or updated at a clock edge is read in the following cycle. The bench samples 1 ns after a falling edge, with the address already set for that cycle. `core_start` after a reset-bit write is due two edges after the write. The bench checks that it is low after the first edge, high after the second, and low again after the third. Flags, records, captured parity and `core_data_vld` are due one edge after the core or bus pulse that causes them. Every check reads at the first sampling point after that edge. `irq` is combinational from the registers and is checked right after the mask write.

// File: rtl/rsecc_pkg.sv
// Shared constants for the Reed-Solomon ECC register front-end.
// Assumes a 32-bit register file addressed in bytes.
package rsecc_pkg;
    localparam int REG_W     = 32;
    localparam int PAR_BYTES = 9;
    localparam int PAR_W     = PAR_BYTES * 8;
    localparam int PAR_WORDS = (PAR_BYTES + 3) / 4;
    localparam int NFLAGS    = 5;
    localparam int CNT_W     = 3;

    // word indices (byte address / 4)
    localparam int W_CTRL = 0;
    localparam int W_DATA = 1;
    localparam int W_PAR  = 2;
    localparam int W_STAT = 5;
    localparam int W_IMSK = 6;
    localparam int W_REC  = 7;

    // control bit positions
    localparam int CB_EN   = 0;
    localparam int CB_RST  = 1;
    localparam int CB_RS   = 2;
    localparam int CB_ENC  = 3;
    localparam int CB_PRDY = 4;

    // status bit positions
    localparam int SB_ERR   = 0;
    localparam int SB_UNCOR = 1;
    localparam int SB_ENC   = 2;
    localparam int SB_DEC   = 3;
    localparam int SB_PAD   = 4;
    localparam int SB_CNT   = 29;

    // parity an encode yields for a page of all 0xFF, byte 0 in the low bits
    localparam logic [PAR_W-1:0] ERASED_PARITY = 72'h6F_B7_FF_8B_F4_58_90_9D_CD;

    typedef struct packed {
        logic prdy;
        logic enc;
        logic rs;
        logic rst;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/rsecc_ctrl.sv
// Control register and run sequencer.
// Holds enable/RS/encode/parity-ready, a one-cycle reset pulse that arms
// a single run, and the busy state between core_start and core_done.
// Assumes the core answers each start with exactly one core_done.
module rsecc_ctrl
    import rsecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [4:0]  wr_bits,
    input  logic        core_done,
    output ctrl_t       ctrl_q,
    output logic        rst_pulse,
    output logic        start,
    output logic        done_evt
);
    logic en_q, rs_q, enc_q, prdy_q, rst_pend, armed, busy;

    // register fields, self-clearing reset, arming and busy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            rs_q     <= 1'b0;
            enc_q    <= 1'b0;
            prdy_q   <= 1'b0;
            rst_pend <= 1'b0;
            armed    <= 1'b0;
            busy     <= 1'b0;
        end else begin
            if (wr_en) begin
                en_q   <= wr_bits[CB_EN];
                rs_q   <= wr_bits[CB_RS];
                enc_q  <= wr_bits[CB_ENC];
                prdy_q <= wr_bits[CB_PRDY];
            end
            if (rst_pend)
                prdy_q <= 1'b0;
            rst_pend <= wr_en & wr_bits[CB_RST];
            if (wr_en && wr_bits[CB_RST])
                armed <= 1'b1;
            else if (start)
                armed <= 1'b0;
            if (rst_pend)
                busy <= 1'b0;
            else if (start)
                busy <= 1'b1;
            else if (done_evt)
                busy <= 1'b0;
        end
    end

    // start once armed, reset settled, enabled, and parity present for decode
    always_comb begin
        start    = armed && !rst_pend && !busy && en_q && (enc_q || prdy_q);
        done_evt = core_done && busy;
        ctrl_q   = '{prdy: prdy_q, enc: enc_q, rs: rs_q, rst: rst_pend, en: en_q};
    end

    assign rst_pulse = rst_pend;

    // R3
    rst_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pend && !wr_en) |=> (!rst_pend && !prdy_q));
    // R5
    dec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !enc_q) |-> prdy_q);
    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/rsecc_parity.sv
// Nine-byte parity window.
// Each byte is written by its bus lane or loaded from the core at the end
// of an encode; an erased-page parity is replaced by all 0xFF.
module rsecc_parity
    import rsecc_pkg::*;
#(
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [3:0]        wr_be,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              cap,
    input  logic [PAR_W-1:0]  cap_data,
    output logic [PAR_W-1:0]  window
);
    logic [PAR_W-1:0] cap_fixed;

    // substitute the erased-page pattern
    always_comb cap_fixed = (cap_data == ERASED_PARITY) ? {PAR_W{1'b1}} : cap_data;

    for (genvar b = 0; b < PAR_BYTES; b++) begin : g_byte
        localparam int WRD  = b / 4;
        localparam int LANE = b % 4;
        // one parity byte: core capture has priority over bus write
        always_ff @(posedge clk) begin
            if (!rst_n)
                window[8*b +: 8] <= 8'h00;
            else if (cap)
                window[8*b +: 8] <= cap_fixed[8*b +: 8];
            else if (wr_en && (int'(wr_word) == WRD) && wr_be[LANE])
                window[8*b +: 8] <= wr_data[8*LANE +: 8];
        end
    end

    // R7
    erased_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && cap_data == ERASED_PARITY) |=> (window == {PAR_W{1'b1}}));
endmodule

// File: rtl/rsecc_status.sv
// Status flags, corrected-error count, interrupt mask, error records, irq.
// Assumes done_evt is already qualified by the sequencer's busy state.
module rsecc_status
    import rsecc_pkg::*;
#(
    parameter int NUM_REC = 4,
    parameter int REC_IW  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          done_evt,
    input  logic                          enc_mode,
    input  logic                          core_err,
    input  logic                          core_uncor,
    input  logic [CNT_W-1:0]              core_cnt,
    input  logic                          pad,
    input  logic                          imsk_we,
    input  logic [NFLAGS-1:0]             imsk_wd,
    input  logic                          rec_clr,
    input  logic                          rec_we,
    input  logic [REC_IW-1:0]             rec_idx,
    input  logic [REG_W-1:0]              rec_wd,
    output logic [NFLAGS-1:0]             flags,
    output logic [CNT_W-1:0]              cnt,
    output logic [NFLAGS-1:0]             imsk,
    output logic [NUM_REC-1:0][REG_W-1:0] recs,
    output logic                          irq
);
    logic [NFLAGS-1:0] set_v;

    // flags raised this cycle by the core
    always_comb begin
        set_v = '0;
        set_v[SB_PAD] = pad;
        if (done_evt) begin
            set_v[SB_ENC]   = enc_mode;
            set_v[SB_DEC]   = !enc_mode;
            set_v[SB_ERR]   = !enc_mode && core_err;
            set_v[SB_UNCOR] = !enc_mode && core_uncor;
        end
    end

    // flags and count: clear on zero write, new events still land
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            cnt   <= '0;
        end else begin
            flags <= (clr ? '0 : flags) | set_v;
            if (done_evt && !enc_mode)
                cnt <= core_cnt;
            else if (clr)
                cnt <= '0;
        end
    end

    // interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            imsk <= '0;
        else if (imsk_we)
            imsk <= imsk_wd;
    end

    for (genvar r = 0; r < NUM_REC; r++) begin : g_rec
        // one error record: cleared by run reset, loaded by the core
        always_ff @(posedge clk) begin
            if (!rst_n || rec_clr)
                recs[r] <= '0;
            else if (rec_we && (int'(rec_idx) == r))
                recs[r] <= rec_wd;
        end
    end

    // masked interrupt
    assign irq = |(flags & imsk);

    // R9
    zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done_evt && !pad) |=> (flags == '0 && cnt == '0));
    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !done_evt && !pad) |=> ($stable(flags) && $stable(cnt)));
    // R10
    rec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_clr && !rec_we) |=> (recs[0] == '0));
endmodule

// File: rtl/rsecc_regfront.sv
// Reed-Solomon ECC register front-end: bus decode, read mux and data port.
// Assumes a single-cycle write bus with combinational read data.
module rsecc_regfront
    import rsecc_pkg::*;
#(
    parameter int NUM_REC = 4,
    parameter int ADDR_W  = 8,
    localparam int REC_IW = (NUM_REC > 1) ? $clog2(NUM_REC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [3:0]        bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              core_start,
    output logic              core_encode,
    output logic              core_rs_mode,
    output logic [PAR_W-1:0]  core_par_out,
    output logic              core_data_vld,
    output logic [REG_W-1:0]  core_data,
    input  logic              core_done,
    input  logic              core_pad_done,
    input  logic              core_err,
    input  logic              core_uncor,
    input  logic [CNT_W-1:0]  core_err_cnt,
    input  logic [PAR_W-1:0]  core_par_in,
    input  logic              core_rec_we,
    input  logic [REC_IW-1:0] core_rec_idx,
    input  logic [REG_W-1:0]  core_rec_data
);
    localparam int WA_W   = ADDR_W - 2;
    localparam int WSEL_W = (PAR_WORDS > 1) ? $clog2(PAR_WORDS) : 1;

    logic [WA_W-1:0]   word;
    logic              in_par, in_rec;
    logic [WSEL_W-1:0] par_sel;
    logic [REC_IW-1:0] rec_sel;
    logic              wr_ctrl, wr_par, wr_imsk, clr_stat, wr_data;
    logic              unused_lo;

    ctrl_t                         ctrl_q;
    logic                          rst_pulse, done_evt;
    logic [PAR_W-1:0]              window;
    logic [32*PAR_WORDS-1:0]       win_ext;
    logic [NFLAGS-1:0]             flags, imsk;
    logic [CNT_W-1:0]              cnt;
    logic [NUM_REC-1:0][REG_W-1:0] recs;

    // address decode into word regions
    always_comb begin
        word      = bus_addr[ADDR_W-1:2];
        unused_lo = ^bus_addr[1:0];
        in_par    = (int'(word) >= W_PAR) && (int'(word) < W_PAR + PAR_WORDS);
        in_rec    = (int'(word) >= W_REC) && (int'(word) < W_REC + NUM_REC);
        par_sel   = WSEL_W'(int'(word) - W_PAR);
        rec_sel   = REC_IW'(int'(word) - W_REC);
        wr_ctrl   = bus_we && (int'(word) == W_CTRL) && bus_be[0];
        wr_imsk   = bus_we && (int'(word) == W_IMSK) && bus_be[0];
        wr_par    = bus_we && in_par;
        wr_data   = bus_we && (int'(word) == W_DATA);
        clr_stat  = bus_we && (int'(word) == W_STAT) && (bus_wdata == '0);
    end

    rsecc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ctrl),
        .wr_bits   (bus_wdata[4:0]),
        .core_done (core_done),
        .ctrl_q    (ctrl_q),
        .rst_pulse (rst_pulse),
        .start     (core_start),
        .done_evt  (done_evt)
    );

    rsecc_parity #(.WSEL_W(WSEL_W)) u_parity (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_par),
        .wr_word  (par_sel),
        .wr_be    (bus_be),
        .wr_data  (bus_wdata),
        .cap      (done_evt && ctrl_q.enc),
        .cap_data (core_par_in),
        .window   (window)
    );

    rsecc_status #(.NUM_REC(NUM_REC), .REC_IW(REC_IW)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_stat),
        .done_evt   (done_evt),
        .enc_mode   (ctrl_q.enc),
        .core_err   (core_err),
        .core_uncor (core_uncor),
        .core_cnt   (core_err_cnt),
        .pad        (core_pad_done),
        .imsk_we    (wr_imsk),
        .imsk_wd    (bus_wdata[NFLAGS-1:0]),
        .rec_clr    (rst_pulse),
        .rec_we     (core_rec_we),
        .rec_idx    (core_rec_idx),
        .rec_wd     (core_rec_data),
        .flags      (flags),
        .cnt        (cnt),
        .imsk       (imsk),
        .recs       (recs),
        .irq        (irq)
    );

    // data word handed to the core the cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_data_vld <= 1'b0;
            core_data     <= '0;
        end else begin
            core_data_vld <= wr_data;
            if (wr_data)
                core_data <= bus_wdata;
        end
    end

    // read multiplexer
    always_comb begin
        win_ext   = {{(32*PAR_WORDS-PAR_W){1'b0}}, window};
        bus_rdata = '0;
        if (int'(word) == W_CTRL)
            bus_rdata[4:0] = ctrl_q;
        else if (in_par)
            bus_rdata = win_ext[32*int'(par_sel) +: 32];
        else if (int'(word) == W_STAT)
            bus_rdata = {cnt, {(REG_W-CNT_W-NFLAGS){1'b0}}, flags};
        else if (int'(word) == W_IMSK)
            bus_rdata[NFLAGS-1:0] = imsk;
        else if (in_rec)
            bus_rdata = recs[rec_sel];
    end

    assign core_encode  = ctrl_q.enc;
    assign core_rs_mode = ctrl_q.rs;
    assign core_par_out = window;

    // R12
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
    // R13
    data_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_data_vld |-> $past(bus_we));
endmodule

// File: tb/rsecc_regfront_bench.sv
module rsecc_regfront_bench;
    localparam int NREC = 4;
    localparam logic [71:0] ERASED = {8'h6F, 8'hB7, 8'hFF, 8'h8B, 8'hF4, 8'h58, 8'h90, 8'h9D, 8'hCD};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, core_start, core_encode, core_rs_mode, core_data_vld;
    logic [71:0] core_par_out;
    logic [31:0] core_data;
    logic        core_done = 0, core_pad_done = 0, core_err = 0, core_uncor = 0;
    logic [2:0]  core_err_cnt = '0;
    logic [71:0] core_par_in = '0;
    logic        core_rec_we = 0;
    logic [1:0]  core_rec_idx = '0;
    logic [31:0] core_rec_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rsecc_regfront #(.NUM_REC(NREC), .ADDR_W(8)) u_rsecc_regfront (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .core_start(core_start),
        .core_encode(core_encode), .core_rs_mode(core_rs_mode), .core_par_out(core_par_out),
        .core_data_vld(core_data_vld), .core_data(core_data), .core_done(core_done),
        .core_pad_done(core_pad_done), .core_err(core_err), .core_uncor(core_uncor),
        .core_err_cnt(core_err_cnt), .core_par_in(core_par_in), .core_rec_we(core_rec_we),
        .core_rec_idx(core_rec_idx), .core_rec_data(core_rec_data));

    task automatic chk(input string req, input string what, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
    endtask

    function automatic logic [71:0] exp_window(input logic [71:0] p);
        return (p == ERASED) ? {72{1'b1}} : p;
    endfunction

    function automatic logic [31:0] stat_word(input logic [2:0] c, input logic [4:0] f);
        return {c, 24'h0, f};
    endfunction

    task automatic done_pulse(input logic e, input logic u, input logic [2:0] c, input logic [71:0] p);
        core_done = 1; core_err = e; core_uncor = u; core_err_cnt = c; core_par_in = p;
        @(negedge clk);
        core_done = 0; core_err = 0; core_uncor = 0; core_err_cnt = '0;
    endtask

    task automatic rec_put(input int i, input logic [31:0] d);
        core_rec_we = 1; core_rec_idx = 2'(i); core_rec_data = d;
        @(negedge clk);
        core_rec_we = 0;
    endtask

    task automatic encode_run(input logic [71:0] p);
        logic [31:0] d;
        logic [71:0] w;
        wr(8'h14, 32'h0, 4'hF);
        wr(8'h00, 32'h0F, 4'h1);
        chk("R4", "start before reset settles", 72'(core_start), 72'h0);
        rd(8'h00, d);
        chk("R3", "reset bit during pulse", 72'(d[1]), 72'h1);
        chk("R4", "start second cycle", 72'(core_start), 72'h1);
        chk("R2", "encode pin", 72'(core_encode), 72'h1);
        @(negedge clk);
        chk("R4", "start single cycle", 72'(core_start), 72'h0);
        done_pulse(0, 0, 3'd0, p);
        rd(8'h14, d);
        chk("R8", "encode status", 72'(d), 72'(stat_word(3'd0, 5'b00100)));
        for (int k = 0; k < 3; k++) begin
            rd(8'(8 + 4 * k), d);
            w[32*k +: 24] = 24'h0;
            if (k < 2) w[32*k +: 32] = d;
            else w[71:64] = d[7:0];
            if (k == 2) chk("R6", "unused lanes of last word", 72'(d[31:8]), 72'h0);
        end
        chk("R7", "captured parity", w, exp_window(p));
        chk("R6", "parity to core", core_par_out, exp_window(p));
    endtask

    initial begin
        logic [31:0] d;
        logic [71:0] p;
        logic [31:0] recv[NREC];
        logic [4:0]  fl;
        logic [2:0]  cn;
        int n;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, d); chk("R1", "ctrl", 72'(d), 72'h0);
        rd(8'h14, d); chk("R1", "status", 72'(d), 72'h0);
        rd(8'h18, d); chk("R1", "mask", 72'(d), 72'h0);
        rd(8'h08, d); chk("R1", "parity word0", 72'(d), 72'h0);
        rd(8'h1C, d); chk("R1", "record0", 72'(d), 72'h0);
        chk("R1", "irq", 72'(irq), 72'h0);
        chk("R1", "start", 72'(core_start), 72'h0);

        // R2 control fields without reset: no run armed
        wr(8'h00, 32'h0D, 4'h1);
        rd(8'h00, d); chk("R2", "ctrl readback", 72'(d), 72'h0D);
        chk("R2", "rs pin", 72'(core_rs_mode), 72'h1);
        chk("R2", "encode pin", 72'(core_encode), 72'h1);
        repeat (3) @(negedge clk);
        chk("R4", "no start without reset write", 72'(core_start), 72'h0);

        // R7 directed erased-page parity, then random encodes
        encode_run(ERASED);
        encode_run({ERASED[71:8], 8'hCC});
        for (int it = 0; it < 10; it++) begin
            p = {8'($urandom), $urandom, $urandom};
            encode_run(p);
        end

        // R5/R6/R8/R10 random decodes
        for (int it = 0; it < 8; it++) begin
            wr(8'h14, 32'h0, 4'hF);
            wr(8'h00, 32'h07, 4'h1);
            repeat (4) begin
                @(negedge clk);
                chk("R5", "no decode start before parity-ready", 72'(core_start), 72'h0);
            end
            p = {8'($urandom), $urandom, $urandom};
            for (int b = 0; b < 9; b++)
                wr(8'(8 + b), 32'(p[8*b +: 8]) << (8 * (b % 4)), 4'(1 << (b % 4)));
            chk("R6", "parity out after byte writes", core_par_out, p);
            rd(8'h0C, d); chk("R6", "parity word1", 72'(d), 72'(p[63:32]));
            wr(8'h00, 32'h15, 4'h1);
            chk("R5", "decode start after parity-ready", 72'(core_start), 72'h1);
            chk("R2", "decode pin", 72'(core_encode), 72'h0);
            @(negedge clk);
            n = $urandom_range(0, NREC);
            for (int r = 0; r < NREC; r++) recv[r] = 32'h0;
            for (int r = 0; r < n; r++) begin
                recv[r] = $urandom;
                rec_put(r, recv[r]);
            end
            fl = {2'b01, 1'b0, ($urandom % 4 == 0), (n > 0)};
            cn = 3'(n);
            done_pulse(fl[0], fl[1], cn, 72'h0);
            rd(8'h14, d); chk("R8", "decode status", 72'(d), 72'(stat_word(cn, fl)));
            for (int r = 0; r < NREC; r++) begin
                rd(8'(8'h1C + 4 * r), d);
                chk("R10", "record", 72'(d), 72'(recv[r]));
            end
            rd(8'h08, d); chk("R7", "decode leaves parity", 72'(d), 72'(p[31:0]));
        end

        // R12 irq against random masks (flags from last decode)
        for (int it = 0; it < 12; it++) begin
            logic [4:0] m;
            m = 5'($urandom);
            wr(8'h18, {27'h0, m}, 4'h1);
            chk("R12", "irq", 72'(irq), 72'(|(m & fl)));
        end
        rd(8'h18, d); chk("R12", "mask readback lane", 72'(d[31:5]), 72'h0);

        // R11 clearing enable keeps status and records
        wr(8'h00, 32'h04, 4'h1);
        rd(8'h14, d); chk("R11", "status after disable", 72'(d), 72'(stat_word(cn, fl)));
        rd(8'h1C, d); chk("R11", "record0 after disable", 72'(d), 72'(recv[0]));

        // R9 nonzero write ignored, zero write clears
        wr(8'h14, 32'h0000_001F, 4'hF);
        rd(8'h14, d); chk("R9", "nonzero write ignored", 72'(d), 72'(stat_word(cn, fl)));
        wr(8'h14, 32'h0, 4'hF);
        rd(8'h14, d); chk("R9", "zero write clears", 72'(d), 72'h0);
        chk("R12", "irq low with no flags", 72'(irq), 72'h0);

        // R8 pad done
        core_pad_done = 1; @(negedge clk); core_pad_done = 0;
        rd(8'h14, d); chk("R8", "pad flag", 72'(d), 72'(stat_word(3'd0, 5'b10000)));

        // R3/R10 reset with parity-ready in the same write
        rec_put(0, 32'hA5A5_0001);
        wr(8'h00, 32'h17, 4'h1);
        repeat (3) begin
            @(negedge clk);
            chk("R3", "no start when reset drops parity-ready", 72'(core_start), 72'h0);
        end
        rd(8'h00, d); chk("R3", "ctrl after reset", 72'(d), 72'h05);
        rd(8'h1C, d); chk("R10", "record cleared by reset bit", 72'(d), 72'h0);

        // R13 data port
        wr(8'h04, 32'hDEAD_BEEF, 4'hF);
        chk("R13", "data valid", 72'(core_data_vld), 72'h1);
        chk("R13", "data word", 72'(core_data), 72'hDEAD_BEEF);
        rd(8'h04, d);
        chk("R13", "data valid drops", 72'(core_data_vld), 72'h0);
        chk("R13", "data reads zero", 72'(d), 72'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule